// File: doc/BRIEF.md
# Delayed Read Discard Timer

This block watches a single delayed-read completion. A bridge parks completion data for a master that first got a retry. The timer starts counting when that data comes back into the bridge. It does not count from the moment the request went out. If the master returns and claims the data before the limit, the entry is released quietly and the count stops. If the master never returns, the parked data is thrown away after 2^15 clocks. A one-cycle discard pulse frees the entry, and an error bit records the event as a PCI-side fault.

The error bit stays set until software writes one to clear it. The block does not hold the data and does not compare addresses. An outside matcher decides that a retry belongs to the held entry and reports it on the retry-hit strobe.

Top module: `drdt_discard_timer`

## Requirements
- R1: With no retry hit, `discard_o` is high in the clock cycle that follows the 2^TMR_W-th rising edge (32768 with the default TMR_W = 15) after the edge that sampled `data_ret_i` high while the entry was free. It is low in every cycle before that.
- R2: When `data_ret_i` is sampled high and the entry is free, `entry_busy_o` goes high after that edge and the hold count starts from zero.
- R3: When `retry_hit_i` is sampled high while the entry is held, `entry_busy_o` is low after that edge, and no discard or error follows. The next held entry counts a full limit from zero.
- R4: An expiry sets `err_flag_o` in the same cycle that `discard_o` is high.
- R5: `discard_o` is high for exactly one cycle, and `entry_busy_o` is low in that cycle.
- R6: When `retry_hit_i` is sampled high on the same edge at which the entry would expire, the retry hit takes priority: the entry is freed, `discard_o` stays low and `err_flag_o` does not change.
- R7: `err_flag_o` stays set until `err_clr_i` is sampled high. If the clear and an expiry fall on the same edge, the flag ends up set.
- R8: `retry_hit_i` has no effect while the entry is free. `data_ret_i` has no effect while the entry is held and does not restart the count.
- R9: After reset, `entry_busy_o`, `discard_o` and `err_flag_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_ret_i | input | 1 | Strobe: completion data for the delayed read has arrived |
| retry_hit_i | input | 1 | Strobe: the requesting master re-accessed the held data |
| err_clr_i | input | 1 | Write-one-to-clear for the error bit |
| discard_o | output | 1 | One-cycle pulse: the held data is dropped |
| err_flag_o | output | 1 | Sticky discard-timeout error bit |
| entry_busy_o | output | 1 | The entry holds data that is waiting for a retry |

## Verification
Two events can fall on one edge: a retry hit and expiry of the same entry, and an expiry and a flag clear. The bench counts exactly 2^15 edges from the data arrival and raises `retry_hit_i` so that it is sampled on the terminal edge. Success means the entry is freed with no discard pulse and an unchanged flag. In a separate run it raises `err_clr_i` on the terminal edge and expects the discard pulse together with a flag that is still set.

// File: rtl/drdt_pkg.sv
package drdt_pkg;

    typedef enum logic [0:0] {
        ENT_FREE = 1'b0,
        ENT_HELD = 1'b1
    } ent_state_e;

    typedef struct packed {
        ent_state_e state;
        logic       discard;
    } ent_regs_t;

endpackage

// File: rtl/drdt_counter.sv
module drdt_counter #(
    parameter int unsigned TMR_W = 15
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clear_i,
    input  logic run_i,
    output logic term_o
);
    logic [TMR_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i) begin
            cnt_d = '0;
        end else if (run_i) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // terminal when the held entry has seen its last allowed cycle
    assign term_o = &cnt_q;
endmodule

// File: rtl/drdt_sticky.sv
module drdt_sticky (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (clr_i) begin
            flag_d = 1'b0;
        end
        if (set_i) begin
            flag_d = 1'b1;   // a new event outranks a clear on the same edge
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            flag_q <= 1'b0;
        end else begin
            flag_q <= flag_d;
        end
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/drdt_discard_timer.sv
module drdt_discard_timer
    import drdt_pkg::*;
#(
    parameter int unsigned TMR_W = 15
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic data_ret_i,
    input  logic retry_hit_i,
    input  logic err_clr_i,
    output logic discard_o,
    output logic err_flag_o,
    output logic entry_busy_o
);
    ent_regs_t regs_d, regs_q;

    logic held;
    logic hit;
    logic expire;
    logic term;

    assign held   = (regs_q.state == ENT_HELD);
    assign hit    = held & retry_hit_i;
    assign expire = held & term & ~retry_hit_i;

    drdt_counter #(
        .TMR_W (TMR_W)
    ) cnt_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clear_i (~held | hit | expire),
        .run_i   (held),
        .term_o  (term)
    );

    drdt_sticky flag_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .set_i  (expire),
        .clr_i  (err_clr_i),
        .flag_o (err_flag_o)
    );

    always_comb begin
        regs_d         = regs_q;
        regs_d.discard = expire;
        unique case (regs_q.state)
            ENT_FREE: begin
                if (data_ret_i) begin
                    regs_d.state = ENT_HELD;
                end
            end
            ENT_HELD: begin
                if (hit || expire) begin
                    regs_d.state = ENT_FREE;
                end
            end
            default: regs_d.state = ENT_FREE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            regs_q <= '{state: ENT_FREE, discard: 1'b0};
        end else begin
            regs_q <= regs_d;
        end
    end

    assign discard_o    = regs_q.discard;
    assign entry_busy_o = held;
endmodule

// File: rtl/drdt_checker.sv
module drdt_checker #(
    parameter int unsigned TMR_W = 15
) (
    input logic clk_i,
    input logic rst_ni,
    input logic data_ret_i,
    input logic retry_hit_i,
    input logic err_clr_i,
    input logic discard_o,
    input logic err_flag_o,
    input logic entry_busy_o
);
    localparam logic [TMR_W:0] LIMIT_V = {1'b1, {TMR_W{1'b0}}};

    logic [TMR_W:0] held_cnt;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            held_cnt <= '0;
        end else if (!entry_busy_o) begin
            held_cnt <= '0;
        end else begin
            held_cnt <= held_cnt + 1'b1;
        end
    end

    AST_DISCARD_AT_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        discard_o |-> (held_cnt == LIMIT_V)); // R1
    AST_NO_OVERRUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        entry_busy_o |-> (held_cnt < LIMIT_V)); // R1
    AST_ARRIVAL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!entry_busy_o && data_ret_i) |=> entry_busy_o); // R2
    AST_HIT_RELEASES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (entry_busy_o && retry_hit_i) |=> (!entry_busy_o && !discard_o)); // R6
    AST_DISCARD_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        discard_o |-> err_flag_o); // R4
    AST_DISCARD_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        discard_o |=> !discard_o); // R5
    AST_DISCARD_FREES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        discard_o |-> !entry_busy_o); // R5
    AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (err_flag_o && !err_clr_i) |=> err_flag_o); // R7
    AST_FLAG_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(err_flag_o) |-> discard_o); // R4
    AST_FREE_IGNORES_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!entry_busy_o && !data_ret_i) |=> !entry_busy_o); // R8
endmodule

bind drdt_discard_timer drdt_checker #(.TMR_W(TMR_W)) chk_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .data_ret_i   (data_ret_i),
    .retry_hit_i  (retry_hit_i),
    .err_clr_i    (err_clr_i),
    .discard_o    (discard_o),
    .err_flag_o   (err_flag_o),
    .entry_busy_o (entry_busy_o)
);

// File: tb/drdt_discard_timer_tb_top.sv
`timescale 1ns/1ps
module drdt_discard_timer_tb_top;
    localparam int unsigned TMR_W = 15;
    localparam int unsigned LIMIT = 1 << TMR_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic data_ret = 1'b0;
    logic retry_hit = 1'b0;
    logic err_clr = 1'b0;
    logic discard, err_flag, busy;

    int n_checks = 0;
    int n_fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    drdt_discard_timer #(.TMR_W(TMR_W)) dut_i (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .data_ret_i   (data_ret),
        .retry_hit_i  (retry_hit),
        .err_clr_i    (err_clr),
        .discard_o    (discard),
        .err_flag_o   (err_flag),
        .entry_busy_o (busy)
    );

    task automatic check(string req, string what, logic act, logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    // arrival sampled on the next edge; returns one negedge later
    task automatic arrive();
        data_ret = 1'b1;
        @(negedge clk);
        data_ret = 1'b0;
    endtask

    task automatic clear_flag();
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
    endtask

    task automatic t_reset();
        check("R9", "busy", busy, 1'b0);
        check("R9", "discard", discard, 1'b0);
        check("R9", "flag", err_flag, 1'b0);
    endtask

    task automatic t_early_hit();
        retry_hit = 1'b1;               // free entry: must be ignored (R8)
        @(negedge clk);
        retry_hit = 1'b0;
        check("R8", "busy after hit while free", busy, 1'b0);
        arrive();
        check("R2", "busy after arrival", busy, 1'b1);
        wait_n(100);
        retry_hit = 1'b1;
        @(negedge clk);
        retry_hit = 1'b0;
        check("R3", "busy after hit", busy, 1'b0);
        check("R3", "discard after hit", discard, 1'b0);
        wait_n(3);
        check("R3", "flag after hit", err_flag, 1'b0);
    endtask

    task automatic t_expire();
        arrive();
        wait_n(LIMIT - 1);
        check("R1", "discard one cycle early", discard, 1'b0);
        check("R1", "busy before limit", busy, 1'b1);
        @(negedge clk);
        check("R1", "discard at limit", discard, 1'b1);
        check("R4", "flag with discard", err_flag, 1'b1);
        check("R5", "busy during discard", busy, 1'b0);
        @(negedge clk);
        check("R5", "discard single cycle", discard, 1'b0);
        wait_n(10);
        check("R7", "flag sticky", err_flag, 1'b1);
        clear_flag();
        check("R7", "flag cleared", err_flag, 1'b0);
    endtask

    task automatic t_hit_at_limit();
        arrive();
        wait_n(LIMIT - 1);
        retry_hit = 1'b1;               // sampled on the terminal edge
        @(negedge clk);
        retry_hit = 1'b0;
        check("R6", "discard with hit at limit", discard, 1'b0);
        check("R6", "busy with hit at limit", busy, 1'b0);
        check("R6", "flag with hit at limit", err_flag, 1'b0);
        @(negedge clk);
        check("R6", "no late discard", discard, 1'b0);
    endtask

    task automatic t_rearrive_and_clear_clash();
        arrive();
        wait_n(20000);
        data_ret = 1'b1;                // held: must not restart (R8)
        @(negedge clk);
        data_ret = 1'b0;
        wait_n(LIMIT - 1 - 20001);
        check("R8", "busy before original limit", busy, 1'b1);
        err_clr = 1'b1;                 // clear on the expiry edge
        @(negedge clk);
        err_clr = 1'b0;
        check("R8", "discard at original limit", discard, 1'b1);
        check("R7", "set beats clear", err_flag, 1'b1);
        clear_flag();
        check("R7", "flag cleared after clash", err_flag, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_early_hit();
        t_expire();
        t_hit_at_limit();
        t_rearrive_and_clear_clash();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end
endmodule